// File: doc/BRIEF.md
# Dual-Channel Operating-System Timer

This block is a register-mapped timer that gives system software two time bases from one input clock. The event channel counts up from zero toward a programmed compare value. When it gets there it sets a sticky flag and stops. The flag drives an interrupt line that a mask bit can gate. The stamp channel is a free-running up-counter that software reads as a timestamp. Its low word is read directly, and the upper bits sit in a buffer that is loaded at the moment the low word is read, so two reads return one consistent wide value.

Each channel has its own divider that turns the input clock into counting ticks at ratios of 1, 4 or 16. Writing ones to a set register starts a channel and writing ones to a separate clear register stops it. A third write-one register zeroes a channel's counter. The bus is a simple word-indexed read and write port: writes take effect at the clock edge and read data is combinational.

Top module: `ostm_top`

## Requirements
- R1: After reset, every counter, the compare value, the divider codes, both enables and the flag are zero. The mask bit is one and `irq` is low.
- R2: The divider word (index 0) holds the event-channel code in bits [1:0] and the stamp-channel code in bits [3:2]. Code 0 gives one count per clock, code 1 one per 4 clocks, and codes 2 and 3 one per 16 clocks. A code written while a channel runs takes effect after that channel's next tick.
- R3: At index 2, writing a 1 to bit 0 or bit 1 enables the event or stamp channel. At index 3, writing a 1 to the same bit disables it, and a disabled channel holds its count. Bits written as 0 leave the channel unchanged. Reading index 2 returns the two enable bits.
- R4: At index 1, writing a 1 to bit 0 or bit 1 zeroes the event or stamp counter and restarts its divider phase. Bits written as 0 have no effect.
- R5: The event counter (index 7) stops on the tick at which it equals the compare value (index 6) and holds that value. In the same cycle, bit 0 of the flag word (index 4) goes to 1.
- R6: A halted event channel resumes counting from its held value when bit 0 is written to the enable-set word. A counter clear also releases it.
- R7: Writing 0 to flag bit 0 clears the flag and writing 1 has no effect. A compare hit in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly when the flag is 1 and mask bit 0 (index 5) is 0.
- R9: The stamp channel counts up on every tick while enabled. Its low word (index 8) is the low STAMP_LO_W bits of the count, so it wraps modulo 2^STAMP_LO_W.
- R10: Reading index 8 loads the upper STAMP_HI_W bits of the stamp count into the buffer at index 9. The buffer changes at no other time.
- R11: Unmapped indices and unused register bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; needed for the stamp buffer load |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Event interrupt, flag and not masked |

## Verification
On every cycle the assertions check the tick spacing after a nonzero divider code, the divider phase restart on a clear, the event counter's hold while halted, the halt that follows a hit, a flag rise only on a hit, the stamp counter's stability without a tick, and the buffer load on a low-word read. Only the bench scenarios can show the actual tick ratios for each code, the exact cycle in which the interrupt rises for a given compare value, and the mask and flag write semantics. The same applies to resuming after a re-enable, wrap of the low word with the buffer carrying the upper part, and zero read-back of reserved bits.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned PHASE_W = 4;

  localparam logic [ADDR_W-1:0] IDX_DIV      = 4'd0;
  localparam logic [ADDR_W-1:0] IDX_ZERO     = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_EN_SET   = 4'd2;
  localparam logic [ADDR_W-1:0] IDX_EN_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_FLAG     = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_MASK     = 4'd5;
  localparam logic [ADDR_W-1:0] IDX_CMP      = 4'd6;
  localparam logic [ADDR_W-1:0] IDX_EVT_CNT  = 4'd7;
  localparam logic [ADDR_W-1:0] IDX_STAMP_LO = 4'd8;
  localparam logic [ADDR_W-1:0] IDX_STAMP_HI = 4'd9;

  // last phase value of a divided period: ratio 4^code, saturating at 16
  function automatic logic [PHASE_W-1:0] period_last(input logic [1:0] code);
    case (code)
      2'd0:    period_last = 4'd0;
      2'd1:    period_last = 4'd3;
      default: period_last = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/ostm_prescaler.sv
module ostm_prescaler
  import ostm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [1:0]         used_q, used_d;

  assign tick = en && (phase_q == period_last(used_q));

  always_comb begin
    phase_d = phase_q;
    used_d  = used_q;
    if (restart || !en) begin
      phase_d = '0;
      used_d  = code;
    end else if (tick) begin
      phase_d = '0;
      used_d  = code;
    end else begin
      phase_d = phase_q + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      used_q  <= '0;
    end else begin
      phase_q <= phase_d;
      used_q  <= used_d;
    end
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != 2'd0) |=> !tick);
  assert_restart_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/ostm_event_ch.sv
module ostm_event_ch #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             zero,
  input  logic             rearm,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             halt_q, halt_d;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = tick && !halt_q && !zero && (cnt_inc == cmp);
  assign count   = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    halt_d = halt_q;
    if (zero) begin
      cnt_d  = '0;
      halt_d = 1'b0;
    end else begin
      if (rearm)            halt_d = 1'b0;
      if (tick && !halt_q)  cnt_d  = cnt_inc;
      if (hit)              halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
    end
  end

  assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !zero && !rearm) |=> $stable(cnt_q));
  assert_hit_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rearm) |=> (halt_q && cnt_q == $past(cmp)));
endmodule

// File: rtl/ostm_stamp_ch.sv
module ostm_stamp_ch #(
  parameter int unsigned LO_W = 32,
  parameter int unsigned HI_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            zero,
  input  logic            capture,
  output logic [LO_W-1:0] lo,
  output logic [HI_W-1:0] hi_buf
);
  localparam int unsigned TOT_W = LO_W + HI_W;

  logic [TOT_W-1:0] cnt_q, cnt_d;
  logic [HI_W-1:0]  hi_q, hi_d;

  assign lo     = cnt_q[LO_W-1:0];
  assign hi_buf = hi_q;

  always_comb begin
    cnt_d = cnt_q;
    hi_d  = hi_q;
    if (zero)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + TOT_W'(1);
    if (capture)   hi_d  = cnt_q[TOT_W-1:LO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !zero) |=> $stable(cnt_q));
  assert_zeroed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (cnt_q == '0));
  assert_buffer_only_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(hi_q));
endmodule

// File: rtl/ostm_top.sv
module ostm_top
  import ostm_pkg::*;
#(
  parameter int unsigned EVT_W      = 32,
  parameter int unsigned STAMP_LO_W = 32,
  parameter int unsigned STAMP_HI_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [3:0]       div_q, div_d;
  logic [1:0]       en_q, en_d;
  logic             flag_q, flag_d;
  logic             mask_q, mask_d;
  logic [EVT_W-1:0] cmp_q, cmp_d;

  logic             wr_div, wr_zero, wr_set, wr_clr, wr_flag, wr_mask, wr_cmp;
  logic [1:0]       zero_ch, tick_ch;
  logic             evt_hit, rearm, capture;
  logic [EVT_W-1:0] evt_count;
  logic [STAMP_LO_W-1:0] stamp_lo;
  logic [STAMP_HI_W-1:0] stamp_hi;

  assign wr_div  = bus_wr && (bus_addr == IDX_DIV);
  assign wr_zero = bus_wr && (bus_addr == IDX_ZERO);
  assign wr_set  = bus_wr && (bus_addr == IDX_EN_SET);
  assign wr_clr  = bus_wr && (bus_addr == IDX_EN_CLR);
  assign wr_flag = bus_wr && (bus_addr == IDX_FLAG);
  assign wr_mask = bus_wr && (bus_addr == IDX_MASK);
  assign wr_cmp  = bus_wr && (bus_addr == IDX_CMP);
  assign zero_ch = wr_zero ? bus_wdata[1:0] : 2'b00;
  assign rearm   = wr_set && bus_wdata[0];
  assign capture = bus_rd && (bus_addr == IDX_STAMP_LO);

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_div
      ostm_prescaler u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q[g]),
        .restart (zero_ch[g]),
        .code    (div_q[2*g +: 2]),
        .tick    (tick_ch[g])
      );
    end
  endgenerate

  ostm_event_ch #(.CNT_W(EVT_W)) u_evt (
    .clk (clk), .rst_n (rst_n), .tick (tick_ch[0]), .zero (zero_ch[0]),
    .rearm (rearm), .cmp (cmp_q), .count (evt_count), .hit (evt_hit)
  );

  ostm_stamp_ch #(.LO_W(STAMP_LO_W), .HI_W(STAMP_HI_W)) u_stamp (
    .clk (clk), .rst_n (rst_n), .tick (tick_ch[1]), .zero (zero_ch[1]),
    .capture (capture), .lo (stamp_lo), .hi_buf (stamp_hi)
  );

  always_comb begin
    div_d  = div_q;
    en_d   = en_q;
    flag_d = flag_q;
    mask_d = mask_q;
    cmp_d  = cmp_q;
    if (wr_div)  div_d  = bus_wdata[3:0];
    if (wr_set)  en_d   = en_q | bus_wdata[1:0];
    if (wr_clr)  en_d   = en_q & ~bus_wdata[1:0];
    if (wr_mask) mask_d = bus_wdata[0];
    if (wr_cmp)  cmp_d  = bus_wdata[EVT_W-1:0];
    if (evt_hit)                      flag_d = 1'b1;
    else if (wr_flag && !bus_wdata[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      en_q   <= '0;
      flag_q <= 1'b0;
      mask_q <= 1'b1;
      cmp_q  <= '0;
    end else begin
      div_q  <= div_d;
      en_q   <= en_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
      cmp_q  <= cmp_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_DIV:      bus_rdata = BUS_W'(div_q);
      IDX_EN_SET:   bus_rdata = BUS_W'(en_q);
      IDX_FLAG:     bus_rdata = BUS_W'(flag_q);
      IDX_MASK:     bus_rdata = BUS_W'(mask_q);
      IDX_CMP:      bus_rdata = BUS_W'(cmp_q);
      IDX_EVT_CNT:  bus_rdata = BUS_W'(evt_count);
      IDX_STAMP_LO: bus_rdata = BUS_W'(stamp_lo);
      IDX_STAMP_HI: bus_rdata = BUS_W'(stamp_hi);
      default:      bus_rdata = '0;
    endcase
  end

  assign irq = flag_q && !mask_q;

  assert_flag_rise_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(evt_hit));
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_flag && !bus_wdata[0])) |=> flag_q);
  assert_disabled_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata[1]) |=> !tick_ch[1]);
endmodule

// File: tb/ostm_top_bench.sv
module ostm_top_bench;
  import ostm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ostm_top #(.EVT_W(32), .STAMP_LO_W(8), .STAMP_HI_W(32)) u_ostm_top (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .irq
  );

  localparam int NV = 8;
  localparam int V_CODE [NV] = '{0, 1, 2, 1, 2, 2, 3, 0};
  localparam int V_WAIT [NV] = '{10, 10, 40, 3, 15, 16, 32, 0};
  localparam int V_EXP  [NV] = '{10, 2, 2, 0, 0, 1, 2, 0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(IDX_DIV, v);      check("R1 div", v, 0);
    rd(IDX_EN_SET, v);   check("R1 enables", v, 0);
    rd(IDX_FLAG, v);     check("R1 flag", v, 0);
    rd(IDX_MASK, v);     check("R1 mask", v, 1);
    rd(IDX_EVT_CNT, v);  check("R1 event count", v, 0);
    rd(IDX_STAMP_LO, v); check("R1 stamp lo", v, 0);
    rd(IDX_STAMP_HI, v); check("R1 stamp hi", v, 0);

    // R2 R9 divider table on the stamp channel
    wr(IDX_EN_SET, 32'h2);
    for (int i = 0; i < NV; i++) begin
      wr(IDX_DIV, 32'(V_CODE[i]) << 2);
      wr(IDX_ZERO, 32'h2);
      repeat (V_WAIT[i]) @(negedge clk);
      rd(IDX_STAMP_LO, v);
      check($sformatf("R2 R9 vector %0d", i), v, 32'(V_EXP[i]));
    end

    // R5 R8 one-shot at divide by 1, compare 5
    wr(IDX_CMP, 32'd5);
    wr(IDX_MASK, 32'd0);
    wr(IDX_ZERO, 32'h1);
    wr(IDX_EN_SET, 32'h1);
    repeat (4) @(negedge clk);
    check("R5 irq before compare", {31'd0, irq}, 0);
    @(negedge clk);
    check("R5 R8 irq at compare", {31'd0, irq}, 1);
    repeat (10) @(negedge clk);
    rd(IDX_EVT_CNT, v);  check("R5 held count", v, 5);
    rd(IDX_FLAG, v);     check("R5 flag set", v, 1);

    // R8 mask, R7 flag write semantics
    wr(IDX_MASK, 32'd1);
    check("R8 masked irq", {31'd0, irq}, 0);
    wr(IDX_MASK, 32'd0);
    check("R8 unmasked irq", {31'd0, irq}, 1);
    wr(IDX_FLAG, 32'd1);
    rd(IDX_FLAG, v);     check("R7 write one ignored", v, 1);
    wr(IDX_FLAG, 32'd0);
    check("R7 irq after clear", {31'd0, irq}, 0);
    rd(IDX_FLAG, v);     check("R7 flag cleared", v, 0);

    // R6 re-enable resumes from held value
    wr(IDX_EN_SET, 32'h1);
    repeat (3) @(negedge clk);
    rd(IDX_EVT_CNT, v);  check("R6 resumed count", v, 8);

    // R3 disable holds, status read-back
    wr(IDX_EN_CLR, 32'h1);
    rd(IDX_EVT_CNT, v);
    repeat (5) @(negedge clk);
    rd(IDX_EVT_CNT, w);  check("R3 disabled holds", w, v);
    rd(IDX_EN_SET, v);   check("R3 status", v, 32'h2);
    wr(IDX_EN_SET, 32'h0);
    rd(IDX_EN_SET, v);   check("R3 zero bits no effect", v, 32'h2);

    // R2 event channel at divide by 4, compare 3
    wr(IDX_CMP, 32'd3);
    wr(IDX_DIV, 32'h1);
    wr(IDX_ZERO, 32'h1);
    wr(IDX_EN_SET, 32'h1);
    repeat (11) @(negedge clk);
    check("R2 irq before 12 clocks", {31'd0, irq}, 0);
    @(negedge clk);
    check("R2 irq at 12 clocks", {31'd0, irq}, 1);
    wr(IDX_FLAG, 32'd0);

    // R4 clear register
    wr(IDX_EN_CLR, 32'h2);
    rd(IDX_STAMP_LO, v);
    wr(IDX_ZERO, 32'h0);
    rd(IDX_STAMP_LO, w); check("R4 zero write no effect", w, v);
    wr(IDX_ZERO, 32'h2);
    rd(IDX_STAMP_LO, v); check("R4 stamp zeroed", v, 0);

    // R9 R10 wrap of the low word and high buffer
    wr(IDX_EN_SET, 32'h2);
    repeat (299) @(negedge clk);
    rd(IDX_STAMP_LO, v); check("R9 low wraps", v, 43);
    rd(IDX_STAMP_HI, v); check("R10 high captured", v, 1);
    repeat (300) @(negedge clk);
    rd(IDX_STAMP_HI, v); check("R10 buffer stable", v, 1);
    rd(IDX_STAMP_LO, v); check("R9 low second", v, 90);
    rd(IDX_STAMP_HI, v); check("R10 high recaptured", v, 2);

    // R11 reserved bits and unmapped index
    rd(4'hF, v);         check("R11 unmapped", v, 0);
    wr(IDX_DIV, 32'hFFFF_FFFF);
    rd(IDX_DIV, v);      check("R11 divider width", v, 32'hF);
    rd(IDX_FLAG, v);     check("R11 flag bits", v & 32'hFFFF_FFFE, 0);

    finished = 1'b1;
    finish_run();
  end
endmodule